// File: doc/BRIEF.md
# USB Device Event Status Word

This block keeps the 32-bit interrupt status word of a USB device controller. The endpoint engines send it single-cycle event pulses: a transfer finished (byte count reached zero or firmware asked to skip the buffer), a SETUP packet arrived cleanly, or a NAK went out. It records each pulse in a sticky bit. It also records a millisecond frame event and a summary bit for device-state changes. All inputs are already in the register clock domain.

Firmware reads the word over a small register bus. It acknowledges events by writing ones to the bits it has handled. An interrupt line is raised while any recorded event is also enabled in a mask that the neighbouring enable register supplies. The frame tick comes from a cycle counter, or from an external start-of-frame strobe when the parameter `FRAME_SRC_EXT` is 1.

Top module: `usb_evt_status`

## Requirements
- R1: While `rst` is high at a rising edge, the status word, the read data and the interrupt line all become zero.
- R2: A pulse on `ep_out_done_i[n]` sets status bit 2n, and a pulse on `ep_in_done_i[n]` sets bit 2n+1, for n from 0 to NUM_EP-1. The bit is visible after the next rising edge.
- R3: A pulse on `setup_ok_i` sets bit 0 (control OUT) and touches no other bit.
- R4: A NAK pulse on `ep_out_nak_i[n]` or `ep_in_nak_i[n]` sets the same bit as a completion only when its enable is high. Endpoint 0 OUT uses `nak_en_ctl_out_i` and endpoint 0 IN uses `nak_en_ctl_in_i`. Every other OUT endpoint uses `nak_en_ep_out_i` and every other IN endpoint uses `nak_en_ep_in_i`.
- R5: Bit 2*NUM_EP (bit 30) is set on a frame tick only while `vbus_ok_i` and `dev_conn_i` are both high. With `FRAME_SRC_EXT`=0 a tick occurs in the MS_CYCLES-th cycle after reset and every MS_CYCLES cycles after that, and `sof_i` is ignored. With `FRAME_SRC_EXT`=1, `sof_i` is the tick.
- R6: Bit 2*NUM_EP+1 (bit 31) is set when any bit of `dev_chg_i` goes from 0 to 1. A change bit that stays high does not set it again.
- R7: A write (`bus_sel_i`=1, `bus_wr_i`=1) to address `REG_ADDR` (0x20) clears every status bit whose `bus_wdata_i` bit is 1. Zero bits in the write, and writes to any other address, leave the word unchanged.
- R8: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: A read (`bus_sel_i`=1, `bus_wr_i`=0) at `REG_ADDR` returns, on `bus_rdata_o` after the next edge, the status word as it stood before that edge. In every other cycle `bus_rdata_o` is zero.
- R10: `irq_o` is high one edge after a cycle in which `status_o & irq_mask_i` is non-zero, and low one edge after a cycle in which it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| ep_out_done_i | input | NUM_EP (15) | OUT completion/skip pulse per endpoint |
| ep_in_done_i | input | NUM_EP (15) | IN completion/skip pulse per endpoint |
| setup_ok_i | input | 1 | Error-free SETUP reception on endpoint 0 |
| ep_out_nak_i | input | NUM_EP (15) | OUT NAK sent, per endpoint |
| ep_in_nak_i | input | NUM_EP (15) | IN NAK sent, per endpoint |
| nak_en_ctl_out_i | input | 1 | NAK enable, endpoint 0 OUT |
| nak_en_ctl_in_i | input | 1 | NAK enable, endpoint 0 IN |
| nak_en_ep_out_i | input | 1 | NAK enable, OUT endpoints 1 and up |
| nak_en_ep_in_i | input | 1 | NAK enable, IN endpoints 1 and up |
| vbus_ok_i | input | 1 | Bus power present after debounce |
| dev_conn_i | input | 1 | Device connect flag |
| sof_i | input | 1 | External frame strobe (used when FRAME_SRC_EXT=1) |
| dev_chg_i | input | DEV_CHG_W (4) | Device status change flags |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte address |
| bus_wdata_i | input | 32 | Write data, ones clear |
| bus_rdata_o | output | 32 | Registered read data |
| irq_mask_i | input | 32 | Per-bit interrupt enable |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse, a clearing write and a read each take effect at the first rising edge after they are driven. The status bit or the read data is therefore due one edge later, and the interrupt line one edge after the status bit, two edges after the event. The frame bit falls due in the cycle that the reference count of edges since reset marks as a tick. The bench drives inputs on falling edges and steps a bench-side reference model at the same rising edge as the design. It compares all outputs on the next falling edge, so each result is checked in exactly the cycle it becomes due.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_WR   = 2'd2
  } bus_op_e;

  // Status bit of an endpoint direction: OUT at 2n, IN at 2n+1.
  function automatic int ep_bit(input int ep, input logic is_in);
    return 2 * ep + (is_in ? 1 : 0);
  endfunction

endpackage

// File: rtl/usb_evt_setmap.sv
module usb_evt_setmap #(
  parameter int NUM_EP = 15
) (
  input  logic [NUM_EP-1:0]   out_done_i,
  input  logic [NUM_EP-1:0]   in_done_i,
  input  logic [NUM_EP-1:0]   out_nak_i,
  input  logic [NUM_EP-1:0]   in_nak_i,
  input  logic                setup_ok_i,
  input  logic                en_ctl_out_i,
  input  logic                en_ctl_in_i,
  input  logic                en_ep_out_i,
  input  logic                en_ep_in_i,
  output logic [2*NUM_EP-1:0] set_o
);
  import usb_evt_pkg::*;

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    logic nak_ok_out;
    logic nak_ok_in;
    logic setup_hit;

    if (n == 0) begin : g_ctl
      assign nak_ok_out = en_ctl_out_i;
      assign nak_ok_in  = en_ctl_in_i;
      assign setup_hit  = setup_ok_i;
    end else begin : g_gen
      assign nak_ok_out = en_ep_out_i;
      assign nak_ok_in  = en_ep_in_i;
      assign setup_hit  = 1'b0;
    end

    assign set_o[ep_bit(n, 1'b0)] = out_done_i[n] | (out_nak_i[n] & nak_ok_out) | setup_hit;
    assign set_o[ep_bit(n, 1'b1)] = in_done_i[n]  | (in_nak_i[n]  & nak_ok_in);
  end

endmodule

// File: rtl/usb_evt_frame_tick.sv
module usb_evt_frame_tick #(
  parameter int MS_CYCLES     = 48000,
  parameter int FRAME_SRC_EXT = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic sof_i,
  input  logic vbus_ok_i,
  input  logic dev_conn_i,
  output logic frame_set_o
);
  localparam int CNT_W = (MS_CYCLES > 2) ? $clog2(MS_CYCLES) : 1;

  logic tick;

  if (FRAME_SRC_EXT != 0) begin : g_ext
    assign tick = sof_i;
  end else begin : g_cnt
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MS_CYCLES - 1);
    logic [CNT_W-1:0] cnt_q;
    logic             unused_sof;

    assign unused_sof = sof_i;
    assign tick       = (cnt_q == LAST);

    always_ff @(posedge clk) begin
      if (rst || tick) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_set_o = tick & vbus_ok_i & dev_conn_i;

endmodule

// File: rtl/usb_evt_devchg.sv
module usb_evt_devchg #(
  parameter int DEV_CHG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DEV_CHG_W-1:0] chg_i,
  output logic                 rise_o
);
  logic [DEV_CHG_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
    end else begin
      prev_q <= chg_i;
    end
  end

  assign rise_o = |(chg_i & ~prev_q);

endmodule

// File: rtl/usb_evt_regif.sv
module usb_evt_regif #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int REG_ADDR = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  import usb_evt_pkg::*;

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  bus_op_e op;

  always_comb begin
    if (!sel_i || (addr_i != HIT_ADDR)) begin
      op = BUS_IDLE;
    end else if (wr_i) begin
      op = BUS_WR;
    end else begin
      op = BUS_RD;
    end
  end

  assign clr_o = (op == BUS_WR) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else begin
      rdata_o <= (op == BUS_RD) ? status_i : '0;
    end
  end

endmodule

// File: rtl/usb_evt_status.sv
module usb_evt_status #(
  parameter int NUM_EP        = 15,
  parameter int DEV_CHG_W     = 4,
  parameter int ADDR_W        = 8,
  parameter int REG_ADDR      = 32,
  parameter int MS_CYCLES     = 48000,
  parameter int FRAME_SRC_EXT = 0,
  localparam int STAT_W       = 2 * NUM_EP + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EP-1:0]    ep_out_done_i,
  input  logic [NUM_EP-1:0]    ep_in_done_i,
  input  logic                 setup_ok_i,
  input  logic [NUM_EP-1:0]    ep_out_nak_i,
  input  logic [NUM_EP-1:0]    ep_in_nak_i,
  input  logic                 nak_en_ctl_out_i,
  input  logic                 nak_en_ctl_in_i,
  input  logic                 nak_en_ep_out_i,
  input  logic                 nak_en_ep_in_i,
  input  logic                 vbus_ok_i,
  input  logic                 dev_conn_i,
  input  logic                 sof_i,
  input  logic [DEV_CHG_W-1:0] dev_chg_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [STAT_W-1:0]    bus_wdata_i,
  output logic [STAT_W-1:0]    bus_rdata_o,
  input  logic [STAT_W-1:0]    irq_mask_i,
  output logic [STAT_W-1:0]    status_o,
  output logic                 irq_o
);
  logic [2*NUM_EP-1:0] ep_set;
  logic                frame_set;
  logic                dev_set;
  logic [STAT_W-1:0]   set_vec;
  logic [STAT_W-1:0]   clr_mask;
  logic [STAT_W-1:0]   status_q;
  logic                irq_q;

  usb_evt_setmap #(.NUM_EP(NUM_EP)) u_setmap (
    .out_done_i   (ep_out_done_i),
    .in_done_i    (ep_in_done_i),
    .out_nak_i    (ep_out_nak_i),
    .in_nak_i     (ep_in_nak_i),
    .setup_ok_i   (setup_ok_i),
    .en_ctl_out_i (nak_en_ctl_out_i),
    .en_ctl_in_i  (nak_en_ctl_in_i),
    .en_ep_out_i  (nak_en_ep_out_i),
    .en_ep_in_i   (nak_en_ep_in_i),
    .set_o        (ep_set)
  );

  usb_evt_frame_tick #(
    .MS_CYCLES     (MS_CYCLES),
    .FRAME_SRC_EXT (FRAME_SRC_EXT)
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .sof_i       (sof_i),
    .vbus_ok_i   (vbus_ok_i),
    .dev_conn_i  (dev_conn_i),
    .frame_set_o (frame_set)
  );

  usb_evt_devchg #(.DEV_CHG_W(DEV_CHG_W)) u_devchg (
    .clk    (clk),
    .rst    (rst),
    .chg_i  (dev_chg_i),
    .rise_o (dev_set)
  );

  usb_evt_regif #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (STAT_W),
    .REG_ADDR (REG_ADDR)
  ) u_regif (
    .clk      (clk),
    .rst      (rst),
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .status_i (status_q),
    .clr_o    (clr_mask),
    .rdata_o  (bus_rdata_o)
  );

  assign set_vec = {dev_set, frame_set, ep_set};

  // A set in the same cycle as a clear keeps the bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_mask) | set_vec;
      irq_q    <= |(status_q & irq_mask_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/usb_evt_status_chk.sv
module usb_evt_status_chk #(
  parameter int NUM_EP   = 15,
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 32,
  localparam int STAT_W  = 2 * NUM_EP + 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EP-1:0] ep_out_done_i,
  input logic              setup_ok_i,
  input logic [NUM_EP-1:0] ep_out_nak_i,
  input logic              nak_en_ctl_out_i,
  input logic              vbus_ok_i,
  input logic              dev_conn_i,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [STAT_W-1:0] bus_wdata_i,
  input logic [STAT_W-1:0] bus_rdata_o,
  input logic [STAT_W-1:0] irq_mask_i,
  input logic [STAT_W-1:0] status_o,
  input logic              irq_o
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);
  localparam int FRAME_BIT = 2 * NUM_EP;

  logic rd_hit;
  logic wr_hit;
  logic ep0_out_cause;

  assign rd_hit        = bus_sel_i && !bus_wr_i && (bus_addr_i == HIT_ADDR);
  assign wr_hit        = bus_sel_i && bus_wr_i && (bus_addr_i == HIT_ADDR);
  assign ep0_out_cause = setup_ok_i || ep_out_done_i[0] || (ep_out_nak_i[0] && nak_en_ctl_out_i);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    AST_OUT_DONE_SETS: assert property (@(posedge clk) disable iff (rst) ep_out_done_i[g] |=> status_o[2*g]); // R2
  end

  AST_SETUP_SETS: assert property (@(posedge clk) disable iff (rst) setup_ok_i |=> status_o[0]); // R3
  AST_CTL_NAK_SETS: assert property (@(posedge clk) disable iff (rst) (ep_out_nak_i[0] && nak_en_ctl_out_i) |=> status_o[0]); // R4
  AST_FRAME_GATED: assert property (@(posedge clk) disable iff (rst) (!(vbus_ok_i && dev_conn_i) && !status_o[FRAME_BIT]) |=> !status_o[FRAME_BIT]); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) (wr_hit && bus_wdata_i[0] && !ep0_out_cause) |=> !status_o[0]); // R7
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst) !rd_hit |=> (bus_rdata_o == '0)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) ((status_o & irq_mask_i) == '0) |=> !irq_o); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst) ((status_o & irq_mask_i) != '0) |=> irq_o); // R10

endmodule

bind usb_evt_status usb_evt_status_chk #(
  .NUM_EP   (NUM_EP),
  .ADDR_W   (ADDR_W),
  .REG_ADDR (REG_ADDR)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .ep_out_done_i    (ep_out_done_i),
  .setup_ok_i       (setup_ok_i),
  .ep_out_nak_i     (ep_out_nak_i),
  .nak_en_ctl_out_i (nak_en_ctl_out_i),
  .vbus_ok_i        (vbus_ok_i),
  .dev_conn_i       (dev_conn_i),
  .bus_sel_i        (bus_sel_i),
  .bus_wr_i         (bus_wr_i),
  .bus_addr_i       (bus_addr_i),
  .bus_wdata_i      (bus_wdata_i),
  .bus_rdata_o      (bus_rdata_o),
  .irq_mask_i       (irq_mask_i),
  .status_o         (status_o),
  .irq_o            (irq_o)
);

// File: tb/usb_evt_status_test.sv
module usb_evt_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEP  = 15;
  localparam int DCW  = 4;
  localparam int MS   = 37;
  localparam logic [7:0] RADDR = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] out_done = '0, in_done = '0, out_nak = '0, in_nak = '0;
  logic        setup_ok = 1'b0;
  logic        en_co = 1'b0, en_ci = 1'b0, en_eo = 1'b0, en_ei = 1'b0;
  logic        vbus = 1'b0, conn = 1'b0, sof = 1'b0;
  logic [3:0]  dchg = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, mask = '0;
  logic [31:0] rdata, status;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [31:0] exp_st = '0, exp_rd = '0;
  logic        exp_irq = 1'b0;
  int          m_cnt = 0;
  logic [3:0]  m_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_evt_status #(.NUM_EP(NEP), .DEV_CHG_W(DCW), .ADDR_W(8), .REG_ADDR(32),
                   .MS_CYCLES(MS), .FRAME_SRC_EXT(0)) uut (
    .clk(clk), .rst(rst),
    .ep_out_done_i(out_done), .ep_in_done_i(in_done), .setup_ok_i(setup_ok),
    .ep_out_nak_i(out_nak), .ep_in_nak_i(in_nak),
    .nak_en_ctl_out_i(en_co), .nak_en_ctl_in_i(en_ci),
    .nak_en_ep_out_i(en_eo), .nak_en_ep_in_i(en_ei),
    .vbus_ok_i(vbus), .dev_conn_i(conn), .sof_i(sof), .dev_chg_i(dchg),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_mask_i(mask), .status_o(status), .irq_o(irq)
  );

  function automatic logic [31:0] set_vector(input logic tick);
    logic [31:0] s = '0;
    for (int n = 0; n < NEP; n++) begin
      s[2*n]   = out_done[n] | (out_nak[n] & ((n == 0) ? en_co : en_eo));
      s[2*n+1] = in_done[n]  | (in_nak[n]  & ((n == 0) ? en_ci : en_ei));
    end
    s[0]  = s[0] | setup_ok;
    s[30] = tick & vbus & conn;
    s[31] = |(dchg & ~m_prev);
    return s;
  endfunction

  task automatic model_update();
    logic        tick;
    logic        hit;
    logic [31:0] clr;
    if (rst) begin
      exp_st = '0; exp_rd = '0; exp_irq = 1'b0; m_cnt = 0; m_prev = '0;
    end else begin
      tick    = (m_cnt == MS - 1);
      hit     = sel && (addr == RADDR);
      clr     = (hit && wr) ? wdata : '0;
      exp_irq = |(exp_st & mask);
      exp_rd  = (hit && !wr) ? exp_st : '0;
      exp_st  = (exp_st & ~clr) | set_vector(tick);
      m_cnt   = tick ? 0 : m_cnt + 1;
      m_prev  = dchg;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2/R3/R4 endpoint bits", {2'b00, status[29:0]}, {2'b00, exp_st[29:0]});
    check("R5 frame bit", {31'd0, status[30]}, {31'd0, exp_st[30]});
    check("R6 device change bit", {31'd0, status[31]}, {31'd0, exp_st[31]});
    check("R9 read data", rdata, exp_rd);
    check("R10 irq", {31'd0, irq}, {31'd0, exp_irq});
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_inputs();
    out_done = '0; in_done = '0; out_nak = '0; in_nak = '0; setup_ok = 1'b0;
    sel = 1'b0; wr = 1'b0; addr = RADDR; wdata = '0; sof = 1'b0;
  endtask

  task automatic clear_all();
    idle_inputs();
    sel = 1'b1; wr = 1'b1; wdata = 32'hFFFF_FFFF;
    step();
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) step();
    // R1: reset state
    check("R1 status after reset", status, 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 irq after reset", {31'd0, irq}, 32'h0);
    rst = 1'b0;
    idle_inputs();
    step();

    // R2: OUT 3 -> bit 6, IN 14 -> bit 29
    out_done[3] = 1'b1; in_done[14] = 1'b1;
    step(); idle_inputs();
    check("R2 completion bits", status, 32'h2000_0040);

    // R7: write all ones clears
    clear_all();
    check("R7 clear all", status, 32'h0);

    // R3: setup sets bit 0 only
    setup_ok = 1'b1; step(); idle_inputs();
    check("R3 setup bit", status, 32'h0000_0001);
    clear_all();

    // R4: NAKs with every enable low do nothing
    out_nak = '1; in_nak = '1; step(); idle_inputs();
    check("R4 nak disabled", status, 32'h0);
    en_ci = 1'b1; out_nak = '1; in_nak = '1; step(); idle_inputs();
    check("R4 control IN enable", status, 32'h0000_0002);
    clear_all(); en_ci = 1'b0; en_eo = 1'b1;
    out_nak = '1; in_nak = '1; step(); idle_inputs();
    check("R4 shared OUT enable", status, 32'h1555_5554);
    clear_all(); en_eo = 1'b0;

    // R8: set and clear in one cycle
    out_done[3] = 1'b1; step(); idle_inputs();
    out_done[3] = 1'b1; sel = 1'b1; wr = 1'b1; wdata = 32'hFFFF_FFFF;
    step(); idle_inputs();
    check("R8 set wins", status, 32'h0000_0040);
    // R7: zero write and wrong address leave the word alone
    sel = 1'b1; wr = 1'b1; wdata = 32'h0; step(); idle_inputs();
    check("R7 zero write", status, 32'h0000_0040);
    sel = 1'b1; wr = 1'b1; addr = 8'h24; wdata = 32'hFFFF_FFFF; step(); idle_inputs();
    check("R7 other address", status, 32'h0000_0040);

    // R9: read returns the word
    sel = 1'b1; wr = 1'b0; step(); idle_inputs();
    check("R9 read value", rdata, 32'h0000_0040);
    step();
    check("R9 idle read data", rdata, 32'h0);
    // R10: mask drives irq
    mask = 32'h0000_0040; step();
    check("R10 irq raised", {31'd0, irq}, 32'h1);
    mask = 32'h0000_0080; step();
    check("R10 irq masked", {31'd0, irq}, 32'h0);
    mask = '0;
    clear_all();

    // R5: frame gated by vbus and connect, sof ignored
    conn = 1'b1; vbus = 1'b0;
    for (int i = 0; i < 80; i++) begin sof = 1'b1; step(); end
    idle_inputs();
    check("R5 no frame without vbus", {31'd0, status[30]}, 32'h0);
    vbus = 1'b1;
    repeat (MS + 2) step();
    check("R5 frame tick", {31'd0, status[30]}, 32'h1);
    vbus = 1'b0; clear_all();

    // R6: rising change bit sets once
    dchg = 4'b0001; step();
    check("R6 change rise", {31'd0, status[31]}, 32'h1);
    clear_all();
    repeat (5) step();
    check("R6 held change no reset", {31'd0, status[31]}, 32'h0);
    dchg = 4'b0100; step();
    check("R6 second rise", {31'd0, status[31]}, 32'h1);
    clear_all();

    // Random traffic against the model
    for (int it = 0; it < 6000; it++) begin
      out_done = 15'($urandom & $urandom & $urandom & $urandom);
      in_done  = 15'($urandom & $urandom & $urandom & $urandom);
      out_nak  = 15'($urandom & $urandom & $urandom);
      in_nak   = 15'($urandom & $urandom & $urandom);
      setup_ok = ($urandom % 20) == 0;
      sof      = $urandom % 2;
      if ($urandom % 32 == 0) {en_co, en_ci, en_eo, en_ei} = 4'($urandom);
      if ($urandom % 64 == 0) vbus = ~vbus;
      if ($urandom % 64 == 0) conn = ~conn;
      if ($urandom % 24 == 0) dchg = dchg ^ 4'($urandom);
      if ($urandom % 40 == 0) mask = $urandom;
      sel   = ($urandom % 3) == 0;
      wr    = $urandom % 2;
      addr  = ($urandom % 4 == 0) ? 8'($urandom) : RADDR;
      wdata = $urandom;
      step();
    end

    finished = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule